// File: doc/BRIEF.md
# Serial response comparator and fail logger

This block sits in a shared memory self-diagnosis controller and checks the read responses of several small memories in parallel. Each memory returns its read word one bit per cycle, least significant bit first, on its own serial line. The controller marks the start of each read word with a context strobe. The strobe carries the global address, the address direction, the nominal read value, the value the current element writes, the element index and the background index. After the strobe comes one valid cycle per bit.

The memories differ in width and depth, and both sizes are fixed per memory at build time. The global address sweep covers the deepest memory, so a shallower memory revisits its own locations. The first visit to a location already applied the current element's write. A revisited location therefore has to be checked against the value that was written, not against the nominal read value. Bits above a memory's width are never compared.

Every mismatching bit becomes a fail record and goes into a small queue. The record holds the memory id, the local address, the bit index, the element index and the background index. Repair logic can read the queue through a head output and a pop strobe. A dump strobe instead moves the head record into a shifter that sends it out serially for off-line analysis.

Top module: `serial_resp_checker`

## Requirements
- R1: After reset, fail_flag, log_count, log_ovf, scan_vld and scan_out are all 0.
- R2: A cycle with rd_start high latches the word context and sets the bit position to 0; rd_start wins over a bit_vld in the same cycle. Each following bit_vld cycle compares resp_ser[m] against bit k of that memory's expected word for every memory m at once, with k counting up from 0.
- R3: Memory m compares only bits 0 to width(m)-1. Bit cycles after the fourth in a word are ignored. Neither case ever produces a fail.
- R4: In an ascending sweep (rd_down=0), memory m expects bits of rd_wr when rd_addr >= depth(m), and bits of rd_exp otherwise. The default depths are 16, 8 and 4 for memories 0, 1 and 2, and the default widths are 4, 3 and 2.
- R5: In a descending sweep (rd_down=1), memory m expects bits of rd_wr when rd_addr < 16 - depth(m), and bits of rd_exp otherwise.
- R6: A fail record is 13 bits, packed from MSB to LSB as memory id[12:11], local address rd_addr mod depth(m) [10:7], bit index[6:5], element[4:2], background[1:0].
- R7: When several memories fail in the same bit cycle, all their records are queued in that cycle, lowest memory id first. Records from one word are queued in bit order.
- R8: The queue holds 4 records. A record arriving when the queue is full is dropped and sets log_ovf. log_ovf and fail_flag, once set, stay set until reset.
- R9: log_pop removes the head record in the next cycle. A log_pop on an empty queue has no effect.
- R10: dump_req, when the shifter is idle and the queue is not empty, removes the head record. From the next cycle, scan_vld is high for 13 cycles while scan_out presents the record LSB first. A dump_req while shifting is ignored. dump_req together with log_pop removes only one record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_start | input | 1 | Latch word context, restart bit position |
| rd_addr | input | 4 | Global address of the word |
| rd_down | input | 1 | 1 for a descending address sweep |
| rd_exp | input | 4 | Nominal read value of the element |
| rd_wr | input | 4 | Value the element writes |
| rd_elem | input | 3 | Element index |
| rd_bg | input | 2 | Background index |
| bit_vld | input | 1 | One response bit is present on every lane |
| resp_ser | input | 3 | Serial response bit of each memory |
| log_pop | input | 1 | Remove the head record |
| dump_req | input | 1 | Shift the head record out |
| fail_flag | output | 1 | Sticky: some fail has been seen |
| log_count | output | 3 | Records in the queue |
| log_head | output | 13 | Head record |
| log_ovf | output | 1 | Sticky: a record was dropped |
| scan_out | output | 1 | Serial record data |
| scan_vld | output | 1 | scan_out carries record data |

## Verification
A wrong bit position or a wrong wrap decision in a lane shows at the ports one cycle after the affected bit cycle. It appears either as a log_count that differs from the predicted fail count or as a head record with the wrong address or bit field. Queue pointer errors show up as records coming out of order or duplicated when the queue is drained with pops. A shifter miscount shows as a scan_vld window of the wrong length or a misaligned serial record. Sticky flags are checked after the queue is drained, so a flag that clears early is caught.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    localparam int NMEM  = 3;
    localparam int MAXW  = 4;
    localparam int AW    = 4;
    localparam int ELW   = 3;
    localparam int BGW   = 2;
    localparam int MIDW  = (NMEM > 1) ? $clog2(NMEM) : 1;
    localparam int BITW  = (MAXW > 1) ? $clog2(MAXW) : 1;
    localparam int IDX_W = $clog2(MAXW + 1);

    typedef struct packed {
        logic [MIDW-1:0] mem_id;
        logic [AW-1:0]   addr;
        logic [BITW-1:0] bit_idx;
        logic [ELW-1:0]  elem;
        logic [BGW-1:0]  bg;
    } fail_entry_t;

    localparam int ENTRY_W = $bits(fail_entry_t);
endpackage

// File: rtl/rsc_lane.sv
// One memory's compare lane: expected-bit choice with wrap correction.
module rsc_lane
    import rsc_pkg::*;
#(
    parameter int WIDTH = MAXW,
    parameter int ABITS = AW,
    localparam int DEPTH = 1 << ABITS
) (
    input  logic            active,
    input  logic [BITW-1:0] bit_idx,
    input  logic            resp_bit,
    input  logic [AW-1:0]   addr,
    input  logic            down,
    input  logic [MAXW-1:0] rd_word,
    input  logic [MAXW-1:0] wr_word,
    output logic            mismatch,
    output logic [AW-1:0]   local_addr
);
    logic wrapped;
    logic exp_bit;
    logic in_range;

    always_comb begin
        // A revisited location already holds the element's written value.
        if (down) begin
            wrapped = ({1'b0, addr} < (AW+1)'((1 << AW) - DEPTH));
        end else begin
            wrapped = ({1'b0, addr} >= (AW+1)'(DEPTH));
        end
        exp_bit    = wrapped ? wr_word[bit_idx] : rd_word[bit_idx];
        in_range   = (int'(bit_idx) < WIDTH);
        mismatch   = active && in_range && (resp_bit != exp_bit);
        local_addr = addr & AW'(DEPTH - 1);
    end
endmodule

// File: rtl/rsc_fail_log.sv
// Fail record queue accepting up to NMEM records per cycle.
module rsc_fail_log
    import rsc_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NMEM-1:0]        push,
    input  fail_entry_t [NMEM-1:0] push_ent,
    input  logic                   pop,
    output fail_entry_t            head,
    output logic [CNT_W-1:0]       count,
    output logic                   ovf
);
    typedef struct packed {
        fail_entry_t [DEPTH-1:0] slots;
        logic [PTR_W-1:0]        rd_ptr;
        logic [CNT_W-1:0]        count;
        logic                    ovf;
    } log_state_t;

    log_state_t s_d, s_q;

    always_comb begin
        int fill;
        s_d  = s_q;
        fill = int'(s_q.count);
        if (pop && fill > 0) begin
            s_d.rd_ptr = s_q.rd_ptr + 1'b1;
            fill       = fill - 1;
        end
        for (int m = 0; m < NMEM; m++) begin
            if (push[m]) begin
                if (fill < DEPTH) begin
                    s_d.slots[PTR_W'(int'(s_d.rd_ptr) + fill)] = push_ent[m];
                    fill = fill + 1;
                end else begin
                    s_d.ovf = 1'b1;
                end
            end
        end
        s_d.count = CNT_W'(fill);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head  = s_q.slots[s_q.rd_ptr];
    assign count = s_q.count;
    assign ovf   = s_q.ovf;

    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.count) <= DEPTH);
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ovf |=> s_q.ovf);
    a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.count == '0 && push == '0) |=> s_q.count == '0);
    a_r7_all_queued: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.count == '0 && $countones(push) <= DEPTH)
        |=> int'(s_q.count) == $past($countones(push)));
endmodule

// File: rtl/rsc_scan_out.sv
// Serializes one fail record, LSB first.
module rsc_scan_out
    import rsc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dump_req,
    input  logic        avail,
    input  fail_entry_t head,
    output logic        accept,
    output logic        scan_out,
    output logic        scan_vld
);
    localparam int REM_W = $clog2(ENTRY_W + 1);

    typedef struct packed {
        logic [ENTRY_W-1:0] sh;
        logic [REM_W-1:0]   remain;
        logic               busy;
    } scan_state_t;

    scan_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        accept = dump_req && avail && !s_q.busy;
        if (s_q.busy) begin
            s_d.sh     = s_q.sh >> 1;
            s_d.remain = s_q.remain - 1'b1;
            if (s_q.remain == REM_W'(1)) s_d.busy = 1'b0;
        end else if (accept) begin
            s_d.sh     = head;
            s_d.remain = REM_W'(ENTRY_W);
            s_d.busy   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign scan_out = s_q.busy & s_q.sh[0];
    assign scan_vld = s_q.busy;

    a_r10_start_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_vld) |-> $past(dump_req));
    a_r10_window_held: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.remain > REM_W'(1)) |=> s_q.busy);
endmodule

// File: rtl/serial_resp_checker.sv
module serial_resp_checker
    import rsc_pkg::*;
#(
    parameter logic [NMEM*8-1:0] MEM_WIDTHS = {8'd2, 8'd3, 8'd4},
    parameter logic [NMEM*8-1:0] MEM_ABITS  = {8'd2, 8'd3, 8'd4},
    parameter int LOG_DEPTH = 4,
    localparam int CNT_W = $clog2(LOG_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_start,
    input  logic [AW-1:0]      rd_addr,
    input  logic               rd_down,
    input  logic [MAXW-1:0]    rd_exp,
    input  logic [MAXW-1:0]    rd_wr,
    input  logic [ELW-1:0]     rd_elem,
    input  logic [BGW-1:0]     rd_bg,
    input  logic               bit_vld,
    input  logic [NMEM-1:0]    resp_ser,
    input  logic               log_pop,
    input  logic               dump_req,
    output logic               fail_flag,
    output logic [CNT_W-1:0]   log_count,
    output logic [ENTRY_W-1:0] log_head,
    output logic               log_ovf,
    output logic               scan_out,
    output logic               scan_vld
);
    typedef struct packed {
        logic [AW-1:0]    addr;
        logic             down;
        logic [MAXW-1:0]  exp;
        logic [MAXW-1:0]  wr;
        logic [ELW-1:0]   elem;
        logic [BGW-1:0]   bg;
        logic [IDX_W-1:0] cnt;
        logic             fail_flag;
    } top_state_t;

    top_state_t s_d, s_q;

    logic                   lane_act;
    logic [NMEM-1:0]        mism;
    logic [AW-1:0]          laddr [NMEM];
    fail_entry_t [NMEM-1:0] push_ent;
    fail_entry_t            head;
    logic                   scan_accept;

    assign lane_act = bit_vld && !rd_start && (s_q.cnt < IDX_W'(MAXW));

    for (genvar m = 0; m < NMEM; m++) begin : g_lane
        rsc_lane #(
            .WIDTH (int'(MEM_WIDTHS[m*8 +: 8])),
            .ABITS (int'(MEM_ABITS[m*8 +: 8]))
        ) u_lane (
            .active     (lane_act),
            .bit_idx    (s_q.cnt[BITW-1:0]),
            .resp_bit   (resp_ser[m]),
            .addr       (s_q.addr),
            .down       (s_q.down),
            .rd_word    (s_q.exp),
            .wr_word    (s_q.wr),
            .mismatch   (mism[m]),
            .local_addr (laddr[m])
        );
        assign push_ent[m] = '{mem_id:  MIDW'(m),
                               addr:    laddr[m],
                               bit_idx: s_q.cnt[BITW-1:0],
                               elem:    s_q.elem,
                               bg:      s_q.bg};
    end

    always_comb begin
        s_d = s_q;
        if (rd_start) begin
            s_d.addr = rd_addr;
            s_d.down = rd_down;
            s_d.exp  = rd_exp;
            s_d.wr   = rd_wr;
            s_d.elem = rd_elem;
            s_d.bg   = rd_bg;
            s_d.cnt  = '0;
        end else if (lane_act) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        if (|mism) s_d.fail_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    rsc_fail_log #(.DEPTH(LOG_DEPTH)) u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (mism),
        .push_ent (push_ent),
        .pop      (scan_accept | log_pop),
        .head     (head),
        .count    (log_count),
        .ovf      (log_ovf)
    );

    rsc_scan_out u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .dump_req (dump_req),
        .avail    (log_count != '0),
        .head     (head),
        .accept   (scan_accept),
        .scan_out (scan_out),
        .scan_vld (scan_vld)
    );

    assign fail_flag = s_q.fail_flag;
    assign log_head  = head;

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fail_flag |=> s_q.fail_flag);
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> s_q.cnt == '0);
    a_r3_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= IDX_W'(MAXW));
    a_r8_fail_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (mism != '0) |=> fail_flag);
endmodule

// File: tb/tb_serial_resp_checker.sv
module tb_serial_resp_checker;
    import rsc_pkg::*;

    typedef struct packed {
        logic [3:0] addr;
        logic       down;
        logic [3:0] exp;
        logic [3:0] wr;
        logic [3:0] r0;
        logic [3:0] r1;
        logic [3:0] r2;
        logic [2:0] elem;
        logic [1:0] bg;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        {4'd2,  1'b0, 4'h0, 4'hF, 4'h0, 4'h0, 4'h0, 3'd0, 2'd0},
        {4'd5,  1'b0, 4'h0, 4'hF, 4'h0, 4'h0, 4'h3, 3'd1, 2'd1},
        {4'd5,  1'b0, 4'h0, 4'hF, 4'h0, 4'h0, 4'h0, 3'd1, 2'd2},
        {4'd9,  1'b0, 4'hA, 4'h5, 4'h8, 4'h5, 4'h1, 3'd2, 2'd3},
        {4'd14, 1'b1, 4'hF, 4'h0, 4'hF, 4'h7, 4'h3, 3'd3, 2'd0},
        {4'd3,  1'b1, 4'hF, 4'h0, 4'hF, 4'h0, 4'h1, 3'd4, 2'd1},
        {4'd0,  1'b0, 4'h0, 4'h0, 4'h8, 4'h8, 4'hC, 3'd5, 2'd2},
        {4'd1,  1'b0, 4'h0, 4'h0, 4'h1, 4'h1, 4'h1, 3'd6, 2'd3}
    };
    localparam int WID [3] = '{4, 3, 2};
    localparam int ABT [3] = '{4, 3, 2};

    logic clk = 0, rst_n = 0;
    logic rd_start = 0, rd_down = 0, bit_vld = 0, log_pop = 0, dump_req = 0;
    logic [3:0] rd_addr = 0, rd_exp = 0, rd_wr = 0;
    logic [2:0] rd_elem = 0;
    logic [1:0] rd_bg = 0;
    logic [2:0] resp_ser = 0;
    logic fail_flag, log_ovf, scan_out, scan_vld;
    logic [2:0] log_count;
    logic [ENTRY_W-1:0] log_head;

    int n_chk = 0, n_bad = 0;
    int exp_n;
    logic [12:0] exp_ent [16];
    logic flag_model = 0;

    always #5 clk = ~clk;

    serial_resp_checker dut (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_addr(rd_addr),
        .rd_down(rd_down), .rd_exp(rd_exp), .rd_wr(rd_wr), .rd_elem(rd_elem),
        .rd_bg(rd_bg), .bit_vld(bit_vld), .resp_ser(resp_ser),
        .log_pop(log_pop), .dump_req(dump_req), .fail_flag(fail_flag),
        .log_count(log_count), .log_head(log_head), .log_ovf(log_ovf),
        .scan_out(scan_out), .scan_vld(scan_vld)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Model of R4..R7: records in bit order, then memory order.
    task automatic build_expect(input vec_t v);
        exp_n = 0;
        for (int k = 0; k < 4; k++) begin
            for (int m = 0; m < 3; m++) begin
                int dep = 1 << ABT[m];
                logic wrap, eb, rb;
                logic [3:0] r;
                r    = (m == 0) ? v.r0 : (m == 1) ? v.r1 : v.r2;
                wrap = v.down ? (int'(v.addr) < 16 - dep) : (int'(v.addr) >= dep);
                eb   = wrap ? v.wr[k] : v.exp[k];
                rb   = r[k];
                if (k < WID[m] && rb != eb) begin
                    exp_ent[exp_n] = {2'(m), 4'(int'(v.addr) % dep), 2'(k), v.elem, v.bg};
                    exp_n++;
                end
            end
        end
    endtask

    task automatic send_word(input vec_t v, input int extra);
        @(negedge clk);
        rd_start = 1; rd_addr = v.addr; rd_down = v.down; rd_exp = v.exp;
        rd_wr = v.wr; rd_elem = v.elem; rd_bg = v.bg;
        for (int k = 0; k < 4 + extra; k++) begin
            @(negedge clk);
            rd_start = 0; bit_vld = 1;
            if (k < 4) resp_ser = {v.r2[k], v.r1[k], v.r0[k]};
            else       resp_ser = 3'b111;
        end
        @(negedge clk);
        bit_vld = 0; resp_ser = 0;
    endtask

    task automatic pop_one();
        log_pop = 1;
        @(negedge clk);
        log_pop = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int shown;
        logic [12:0] got;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 fail_flag", fail_flag, 0);
        chk("R1 log_count", log_count, 0);
        chk("R1 log_ovf", log_ovf, 0);
        chk("R1 scan_vld", scan_vld, 0);
        chk("R1 scan_out", scan_out, 0);
        rst_n = 1;
        @(negedge clk);

        // Table walk: R2..R7 and the sticky flag of R8
        for (int i = 0; i < NV; i++) begin
            build_expect(VEC[i]);
            send_word(VEC[i], 0);
            if (exp_n > 0) flag_model = 1;
            shown = (exp_n > 4) ? 4 : exp_n;
            chk($sformatf("R2/R4/R5/R7 count vec%0d", i), log_count, shown);
            chk($sformatf("R8 flag vec%0d", i), fail_flag, flag_model);
            for (int j = 0; j < shown; j++) begin
                chk($sformatf("R6 record vec%0d #%0d", i, j), log_head, exp_ent[j]);
                pop_one();
            end
            chk($sformatf("R9 drained vec%0d", i), log_count, 0);
        end
        chk("R8 no ovf yet", log_ovf, 0);

        // R3: extra bit cycles past the word are ignored
        send_word('{addr:4'd2, down:1'b0, exp:4'h0, wr:4'hF, r0:4'h0, r1:4'h0,
                    r2:4'h0, elem:3'd0, bg:2'd0}, 2);
        chk("R3 extra bits ignored", log_count, 0);

        // R8 overflow: 9 fails, only 4 kept
        send_word('{addr:4'd0, down:1'b0, exp:4'h0, wr:4'h0, r0:4'hF, r1:4'h7,
                    r2:4'h3, elem:3'd7, bg:2'd1}, 0);
        chk("R8 count capped", log_count, 4);
        chk("R8 ovf set", log_ovf, 1);
        chk("R7 head mem0 first", log_head, {2'd0, 4'd0, 2'd0, 3'd7, 2'd1});

        // R10 dump together with pop: one record leaves, it is serialized
        dump_req = 1; log_pop = 1;
        @(negedge clk);
        dump_req = 0; log_pop = 0;
        chk("R10 single removal", log_count, 3);
        got = '0;
        for (int k = 0; k < 13; k++) begin
            chk($sformatf("R10 vld bit%0d", k), scan_vld, 1);
            got[k] = scan_out;
            if (k == 2) dump_req = 1;
            if (k == 3) dump_req = 0;
            @(negedge clk);
        end
        chk("R10 serial record", got, {2'd0, 4'd0, 2'd0, 3'd7, 2'd1});
        chk("R10 busy dump ignored", log_count, 3);
        chk("R10 window ends", scan_vld, 0);
        chk("R9 head after dump", log_head, {2'd1, 4'd0, 2'd0, 3'd7, 2'd1});

        // R9: drain, then pop on empty
        for (int j = 0; j < 3; j++) pop_one();
        chk("R9 empty", log_count, 0);
        pop_one();
        chk("R9 pop on empty", log_count, 0);
        dump_req = 1;
        @(negedge clk);
        dump_req = 0;
        @(negedge clk);
        chk("R10 dump on empty", scan_vld, 0);
        chk("R8 ovf sticky", log_ovf, 1);
        chk("R8 flag sticky", fail_flag, 1);

        finish_run();
    end
endmodule